// File: doc/BRIEF.md
# PCI Target Read Prefetch Sequencer

This block sits on the target side of a bridge between a PCI bus and system memory. When a bus command arrives (a four-bit command code and a 32-bit address, captured in the address phase), it decides whether the bridge claims the cycle or declines it. For claimed memory reads it then issues a stream of word fetch requests to a simple system-memory port. The stream uses one valid/ready handshake per word.

The length of the stream depends on three things: the command, the word offset of the address within its 32-byte line, and a speculative-read control input. A plain memory read fetches from the addressed word through to the end of its line. A read-multiple command always continues through the whole following line. A plain read also continues through the following line when speculative mode is on. A memory write is claimed but causes no fetches. Every other command code is declined, including the reserved codes, the configuration codes and the dual-address code. A one-cycle done pulse closes each read stream. New commands are taken only while the block is idle.

Top module: `pci_rd_prefetch_seq`

## Requirements
- R1: Code 4'b0110 (memory read), accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge, raises `claim` for exactly the one cycle after that edge, and `decline` stays low.
- R2: Code 4'b0111 (memory write) raises `claim` for one cycle and produces no fetch request and no `done` pulse. `cmd_ready` is high again in the cycle after the claim.
- R3: Every code other than 4'b0110, 4'b0111 and 4'b1100 is declined, including 4'b1000, 4'b1001, 4'b1010, 4'b1011 and 4'b1101. Declining raises `decline` for one cycle, leaves `claim` low and issues no fetch.
- R4: A plain read (spec off) issues 8 minus addr[4:2] requests. The first request is at the address with bits [1:0] cleared, and each later one is 4 bytes above the one before.
- R5: Code 4'b1100 (read multiple) issues 16 minus addr[4:2] requests at consecutive word addresses. The stream therefore covers the rest of the line and then all 8 words starting at line base plus 32.
- R6: With `spec_rd_en` high at acceptance, code 4'b0110 also issues the 8 next-line requests. The input does not change the length for 4'b1100 and does not cause fetches for writes.
- R7: While `fetch_valid` is high and `fetch_ready` is low, `fetch_valid` stays high and `fetch_addr` holds its value. A request counts as issued only at an edge where both are high.
- R8: `done` is high for exactly the one cycle after the edge that issues the last request of a read. `cmd_ready` is high in the cycle after that.
- R9: `cmd_ready` is high only while idle. A `cmd_valid` given while it is low is ignored: it causes no claim or decline and does not change the stream.
- R10: After reset, `cmd_ready` is high and `claim`, `decline`, `fetch_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 4 | Bus command code |
| cmd_addr | input | 32 | Byte address from the address phase |
| spec_rd_en | input | 1 | Speculative read: plain reads also fetch the next line |
| cmd_ready | output | 1 | Block is idle and will accept a command |
| claim | output | 1 | One-cycle pulse: the cycle is claimed |
| decline | output | 1 | One-cycle pulse: the cycle is not claimed |
| fetch_valid | output | 1 | A word fetch request is presented |
| fetch_addr | output | 32 | Byte address of the requested word |
| fetch_ready | input | 1 | Memory port takes the request |
| done | output | 1 | One-cycle pulse after the last request of a read |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4-byte words and 8-word lines. With these values all eight start offsets are reachable, so stream lengths run from 1 word (a plain read at the last word) up to 16 words (read multiple at offset 0). Randomly gated `fetch_ready` exercises stalls at every position in a stream, including the final word. Commands driven during a stream probe the idle-only acceptance rule.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        K_DECLINE  = 2'd0,
        K_RD       = 2'd1,
        K_RD_MULTI = 2'd2,
        K_WR       = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RESP  = 2'd1,
        S_FETCH = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;

    localparam logic [3:0] CODE_MEM_RD       = 4'b0110;
    localparam logic [3:0] CODE_MEM_WR       = 4'b0111;
    localparam logic [3:0] CODE_MEM_RD_MULTI = 4'b1100;

    function automatic cmd_kind_e classify(input logic [3:0] code);
        case (code)
            CODE_MEM_RD:       return K_RD;
            CODE_MEM_WR:       return K_WR;
            CODE_MEM_RD_MULTI: return K_RD_MULTI;
            default:           return K_DECLINE;
        endcase
    endfunction

endpackage

// File: rtl/pfs_cmd_decode.sv
module pfs_cmd_decode
    import pfs_pkg::*;
(
    input  logic [3:0] code,
    input  logic       spec,
    output cmd_kind_e  kind,
    output logic       is_read,
    output logic       add_line
);
    always_comb begin
        kind     = classify(code);
        is_read  = (kind == K_RD) || (kind == K_RD_MULTI);
        add_line = (kind == K_RD_MULTI) || ((kind == K_RD) && spec);
    end
endmodule

// File: rtl/pfs_len_calc.sv
module pfs_len_calc #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int LINE_WORDS = 8,
    parameter int CNT_W      = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              add_line,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  count
);
    localparam int OFF_W = $clog2(WORD_BYTES);
    localparam int IDX_W = $clog2(LINE_WORDS);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(WORD_BYTES - 1);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx        = addr[OFF_W +: IDX_W];
        start_addr = addr & ~OFF_MASK;
        count      = CNT_W'(LINE_WORDS) - CNT_W'(idx)
                   + (add_line ? CNT_W'(LINE_WORDS) : CNT_W'(0));
    end
endmodule

// File: rtl/pfs_fetch_gen.sv
module pfs_fetch_gen #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic              last_hs
);
    logic [CNT_W-1:0] remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic hs;

    assign valid   = (remain_q != '0);
    assign addr    = addr_q;
    assign hs      = valid && ready;
    assign last_hs = hs && (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            addr_q   <= '0;
        end else if (load) begin
            remain_q <= load_count;
            addr_q   <= load_addr;
        end else if (hs) begin
            remain_q <= remain_q - CNT_W'(1);
            addr_q   <= addr_q + ADDR_W'(WORD_BYTES);
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !load) |=> (valid && $stable(addr)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hs && !load) |=> (!valid || addr == $past(addr) + ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/pci_rd_prefetch_seq.sv
module pci_rd_prefetch_seq
    import pfs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              spec_rd_en,
    output logic              cmd_ready,
    output logic              claim,
    output logic              decline,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ready,
    output logic              done
);
    localparam int CNT_W = $clog2(2 * LINE_WORDS + 1);

    seq_state_e        state_q;
    logic [3:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic              spec_q;

    cmd_kind_e         kind;
    logic              is_read;
    logic              add_line;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  count;
    logic              gen_load;
    logic              last_hs;
    logic              accept;

    pfs_cmd_decode u_dec (
        .code     (code_q),
        .spec     (spec_q),
        .kind     (kind),
        .is_read  (is_read),
        .add_line (add_line)
    );

    pfs_len_calc #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .LINE_WORDS (LINE_WORDS),
        .CNT_W      (CNT_W)
    ) u_len (
        .addr       (addr_q),
        .add_line   (add_line),
        .start_addr (start_addr),
        .count      (count)
    );

    pfs_fetch_gen #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .CNT_W      (CNT_W)
    ) u_gen (
        .clk        (clk),
        .rst        (rst),
        .load       (gen_load),
        .load_addr  (start_addr),
        .load_count (count),
        .ready      (fetch_ready),
        .valid      (fetch_valid),
        .addr       (fetch_addr),
        .last_hs    (last_hs)
    );

    assign cmd_ready = (state_q == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign claim     = (state_q == S_RESP) && (kind != K_DECLINE);
    assign decline   = (state_q == S_RESP) && (kind == K_DECLINE);
    assign done      = (state_q == S_DONE);
    assign gen_load  = (state_q == S_RESP) && is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            code_q  <= '0;
            addr_q  <= '0;
            spec_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    code_q  <= cmd_code;
                    addr_q  <= cmd_addr;
                    spec_q  <= spec_rd_en;
                    state_q <= S_RESP;
                end
                S_RESP:  state_q <= is_read ? S_FETCH : S_IDLE;
                S_FETCH: if (last_hs) state_q <= S_DONE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R1
    claim_decline_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({claim, decline}));

    // R1
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (claim || decline) |=> !(claim || decline));

    // R3
    decline_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        decline |=> (cmd_ready && !fetch_valid));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid || done) |-> !cmd_ready);

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (cmd_ready && !done && !fetch_valid));
endmodule

// File: tb/pci_rd_prefetch_seq_tb.sv
`timescale 1ns/1ps
module pci_rd_prefetch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [31:0] cmd_addr;
    logic        spec_rd_en;
    logic        cmd_ready;
    logic        claim;
    logic        decline;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic        fetch_ready;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pci_rd_prefetch_seq dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .spec_rd_en(spec_rd_en), .cmd_ready(cmd_ready),
        .claim(claim), .decline(decline), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_ready(fetch_ready), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [3:0] c, input logic [31:0] a,
                                     input logic s);
        if (c == 4'b0110) return 8 - int'(a[4:2]) + (s ? 8 : 0);
        if (c == 4'b1100) return 16 - int'(a[4:2]);
        return 0;
    endfunction

    function automatic bit exp_claim(input logic [3:0] c);
        return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100);
    endfunction

    task automatic run_cmd(input logic [3:0] c, input logic [31:0] a, input logic s);
        int n;
        int exp_n;
        int guard;
        logic [31:0] exp_a;
        exp_n = exp_count(c, a, s);
        exp_a = {a[31:2], 2'b00};
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R9", "ready when idle", 32'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; spec_rd_en = s;
        @(negedge clk);
        cmd_valid = 1'b0; spec_rd_en = ~s;
        if (exp_claim(c)) begin
            chk(claim == 1'b1 && decline == 1'b0, "R1", "claim pulse",
                {30'd0, claim, decline}, 32'd2);
        end else begin
            chk(claim == 1'b0 && decline == 1'b1, "R3", "decline pulse",
                {30'd0, claim, decline}, 32'd1);
        end
        if (exp_n == 0) begin
            @(negedge clk);
            chk(cmd_ready && !fetch_valid && !done && !claim && !decline, "R2",
                "no fetch after non-read", {28'd0, cmd_ready, fetch_valid, done, claim}, 32'h8);
            return;
        end
        n = 0;
        guard = 0;
        while (n < exp_n && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (guard == 2) begin
                cmd_valid = 1'b1; cmd_code = 4'b0111; cmd_addr = $urandom;
            end else begin
                cmd_valid = 1'b0;
            end
            chk(fetch_valid && !cmd_ready && !claim && !decline && !done, "R9",
                "busy stream state", {27'd0, fetch_valid, cmd_ready, claim, decline, done}, 32'h10);
            chk(fetch_addr == exp_a, (exp_n > 8 ? "R5" : "R4"), "fetch address",
                fetch_addr, exp_a);
            fetch_ready = ($urandom % 3) != 0;
            if (fetch_ready) begin
                n++;
                exp_a = exp_a + 4;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        fetch_ready = 1'b0;
        chk(done && !fetch_valid, "R8", "done after last request",
            {30'd0, done, fetch_valid}, 32'd2);
        chk(n == exp_n, "R7", "request count", n, exp_n);
        @(negedge clk);
        chk(cmd_ready && !done && !claim, "R8", "idle after done",
            {29'd0, cmd_ready, done, claim}, 32'd4);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; cmd_valid = 1'b0; cmd_code = '0; cmd_addr = '0;
        spec_rd_en = 1'b0; fetch_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !claim && !decline && !fetch_valid && !done, "R10",
            "reset state", {27'd0, cmd_ready, claim, decline, fetch_valid, done}, 32'h10);
        // R4 directed offsets
        run_cmd(4'b0110, 32'h1000_0000, 1'b0);
        run_cmd(4'b0110, 32'h1000_001F, 1'b0);
        run_cmd(4'b0110, 32'h2000_0046, 1'b0);
        // R5 read multiple, including last word of line
        run_cmd(4'b1100, 32'h3000_001C, 1'b0);
        run_cmd(4'b1100, 32'h3000_0100, 1'b1);
        // R6 speculative plain read and speculative write
        run_cmd(4'b0110, 32'h4000_000C, 1'b1);
        run_cmd(4'b0111, 32'h4000_0010, 1'b1);
        // R2 write, R3 declined codes
        run_cmd(4'b0111, 32'h5000_0000, 1'b0);
        run_cmd(4'b1000, 32'h6000_0000, 1'b1);
        run_cmd(4'b1001, 32'h6000_0004, 1'b0);
        run_cmd(4'b1010, 32'h6000_0008, 1'b0);
        run_cmd(4'b1011, 32'h6000_000C, 1'b1);
        run_cmd(4'b1101, 32'h6000_0010, 1'b1);
        for (int i = 0; i < 80; i++) begin
            logic [3:0] c;
            case ($urandom % 4)
                0: c = 4'b0110;
                1: c = 4'b1100;
                2: c = 4'b0111;
                default: c = 4'($urandom);
            endcase
            run_cmd(c, $urandom, 1'($urandom));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule